// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter with Byte Queue

This block serialises bytes into bit-oriented synchronous frames of the HDLC/SDLC kind. A producer streams bytes into a four-entry queue over a valid/ready interface. The frame runs from the first queued byte until the queue is empty at a byte boundary. Each frame gets an opening flag, zero-bit insertion over the payload and check field, a complemented CRC-16 check field and a closing flag. None of this needs a command from the producer.

The serial side advances only on a bit-tick enable supplied by the surrounding clock logic. The line can be sent as plain NRZ or as NRZI. The request-to-send output (active low) brackets each frame. A status latch reports that the frame was closed because the queue ran dry, and it clears itself when the next frame opens.

Back-pressure works like this. A byte is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly when four bytes are waiting. While `in_ready` is low, the producer holds `in_data` and `in_valid`, and nothing it presents is taken. The line-mode input may only change while `rts_n` is high.

Top module: `hdlc_frame_tx`

## Requirements
- R1: The queue holds up to 4 bytes. `in_ready` is high exactly when fewer than 4 bytes are waiting. A byte offered while `in_ready` is low is discarded and never appears on the line.
- R2: Out of reset, and between frames, `txd` is 1 and `rts_n` is 1.
- R3: On a bit tick in which the block is idle and at least one byte is waiting, `rts_n` goes low while `txd` keeps its idle level. The next 8 ticks send the flag 0x7E, least significant bit first (0,1,1,1,1,1,1,0).
- R4: After the opening flag, the bytes go out in write order, least significant bit first, back to back for as long as a byte is waiting at each byte boundary.
- R5: Within the payload and the check field, a 0 is inserted after every run of five consecutive 1 bits. Inserted zeros are not fed to the CRC, and the flags are never altered.
- R6: The check field is the CRC-16 with generator x^16+x^12+x^5+1 (reflected constant 0x8408), preset to 0xFFFF and run over the payload bits in line order. It is sent complemented, least significant bit first.
- R7: When the queue is empty at the end of a byte, the check field follows and then a closing flag 0x7E. `eom_flag` is set on the tick that starts the check field.
- R8: `eom_flag` is cleared on the tick that opens a new frame, so it reads 0 whenever `rts_n` has just fallen.
- R9: With `nrzi_mode` high, a 0 bit inverts `txd` and a 1 bit leaves it unchanged. The first bit is coded against the idle level 1.
- R10: `rts_n` returns high one tick after the last closing-flag bit was put on the line, which is after that bit has been held for a full bit period. On that same tick, `txd` is forced to 1.
- R11: `bit_en` pulses no more often than once every 4 clocks.
- R12: `txd`, `rts_n` and `eom_flag` change only on clock edges where `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Serial bit tick, one clock wide |
| nrzi_mode | input | 1 | 1 selects NRZI line coding, 0 selects NRZ |
| in_valid | input | 1 | Producer offers a byte |
| in_data | input | 8 | Byte offered by the producer |
| in_ready | output | 1 | Queue can take a byte |
| txd | output | 1 | Serial line |
| rts_n | output | 1 | Request to send, low for the whole frame |
| eom_flag | output | 1 | Set when a frame was closed because the queue ran dry |

## Verification
The hardest case to reach is a zero insertion on a boundary: a run of ones that spans two payload bytes, that carries into the check field, or that ends on the last check bit, so that the inserted zero sits right against the closing flag. The stimulus uses payloads of 0xFF, 0x7F, 0xFE and 0x1F/0xF8 to create runs across bytes. The reference model computes the check field independently, and the payload tables are chosen so that some of those check fields hold long runs of ones. The rejected-byte case is reached by holding `bit_en` off, so the queue fills and stays full while a further byte is offered.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_CLOSE,
    ST_END
  } tx_state_e;

  localparam logic [7:0] FLAG_PATTERN = 8'h7E;
  localparam int         FLAG_BITS    = 8;
  localparam int         RUN_LIMIT    = 5;

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          not_empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;
  logic          push;

  assign in_ready  = (level != FULL_LVL);
  assign not_empty = (level != '0);
  assign push      = in_valid && in_ready;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + AW'(1);
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + AW'(1);
      case ({push, pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end

  AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !pop) |=> !in_ready); // R1
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> not_empty); // R4

endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = 16'h8408
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic feed,
  input  logic bit_in,
  input  logic drain,
  output logic fcs_bit
);
  logic [W-1:0] crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '1;
    end else if (init) begin
      crc <= '1;
    end else if (feed) begin
      crc <= (crc >> 1) ^ ((crc[0] ^ bit_in) ? POLY : '0);
    end else if (drain) begin
      crc <= {1'b1, crc[W-1:1]};
    end
  end

  assign fcs_bit = ~crc[0];

  AST_CRC_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({init, feed, drain}) <= 1); // R6

endmodule

// File: rtl/hdlc_tx_line.sv
module hdlc_tx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic bit_in,
  input  logic nrzi,
  input  logic mark,
  output logic txd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      txd <= 1'b1;
    else if (mark)   txd <= 1'b1;
    else if (load)   txd <= nrzi ? (bit_in ? txd : ~txd) : bit_in;
  end

  AST_NRZI_ZERO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !mark && nrzi && !bit_in) |=> (txd != $past(txd))); // R9
  AST_MARK_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mark |=> txd); // R10

endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
  import hdlc_tx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int FIFO_DEPTH  = 4,
  parameter int FCS_W       = 16,
  parameter int MIN_BIT_GAP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          nrzi_mode,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          txd,
  output logic          rts_n,
  output logic          eom_flag
);
  localparam int SPAN = (FCS_W > DW) ? FCS_W : DW;
  localparam int IW   = $clog2(SPAN);
  localparam int DIW  = $clog2(DW);
  localparam int RW   = $clog2(RUN_LIMIT + 1);
  localparam int GW   = $clog2(MIN_BIT_GAP) + 1;
  localparam logic [IW-1:0] FLAG_LAST = IW'(FLAG_BITS - 1);
  localparam logic [IW-1:0] DATA_LAST = IW'(DW - 1);
  localparam logic [IW-1:0] FCS_LAST  = IW'(FCS_W - 1);
  localparam logic [RW-1:0] RUN_MAX   = RW'(RUN_LIMIT);

  tx_state_e     state;
  logic [IW-1:0] idx;
  logic [DW-1:0] shreg;
  logic [RW-1:0] ones;
  logic          rts_q, eom_q;

  logic          not_empty, pop;
  logic [DW-1:0] head;
  logic          fcs_bit;
  logic          in_frame, stuff, step, load;
  logic          cur_bit, tx_bit;
  logic          crc_init, crc_feed, crc_drain, mark;

  hdlc_tx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .pop(pop), .head(head), .not_empty(not_empty)
  );

  hdlc_tx_crc #(.W(FCS_W), .POLY(FCS_W'(16'h8408))) u_crc (
    .clk(clk), .rst_n(rst_n),
    .init(crc_init), .feed(crc_feed), .bit_in(tx_bit),
    .drain(crc_drain), .fcs_bit(fcs_bit)
  );

  hdlc_tx_line u_line (
    .clk(clk), .rst_n(rst_n),
    .load(load), .bit_in(tx_bit), .nrzi(nrzi_mode),
    .mark(mark), .txd(txd)
  );

  assign in_frame = (state == ST_OPEN) || (state == ST_DATA) ||
                    (state == ST_FCS)  || (state == ST_CLOSE);
  assign stuff    = (ones == RUN_MAX);
  assign step     = bit_en && !stuff;
  assign load     = bit_en && in_frame;

  always_comb begin
    case (state)
      ST_OPEN, ST_CLOSE: cur_bit = FLAG_PATTERN[idx[2:0]];
      ST_DATA:           cur_bit = shreg[idx[DIW-1:0]];
      ST_FCS:            cur_bit = fcs_bit;
      default:           cur_bit = 1'b1;
    endcase
  end

  assign tx_bit    = stuff ? 1'b0 : cur_bit;
  assign crc_init  = step && (state == ST_IDLE) && not_empty;
  assign crc_feed  = step && (state == ST_DATA);
  assign crc_drain = step && (state == ST_FCS);
  assign mark      = bit_en && (state == ST_END);
  assign pop       = step && (((state == ST_OPEN) && (idx == FLAG_LAST)) ||
                              ((state == ST_DATA) && (idx == DATA_LAST) && not_empty));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      shreg <= '0;
      ones  <= '0;
      rts_q <= 1'b1;
      eom_q <= 1'b0;
    end else if (bit_en) begin
      if (load) begin
        if (stuff)
          ones <= '0;
        else if ((state == ST_DATA) || (state == ST_FCS))
          ones <= tx_bit ? ones + RW'(1) : '0;
        else
          ones <= '0;
      end
      if (!stuff) begin
        case (state)
          ST_IDLE: begin
            if (not_empty) begin
              state <= ST_OPEN;
              idx   <= '0;
              rts_q <= 1'b0;
              eom_q <= 1'b0;
            end
          end
          ST_OPEN: begin
            if (idx == FLAG_LAST) begin
              state <= ST_DATA;
              idx   <= '0;
              shreg <= head;
            end else begin
              idx <= idx + IW'(1);
            end
          end
          ST_DATA: begin
            if (idx == DATA_LAST) begin
              idx <= '0;
              if (not_empty) begin
                shreg <= head;
              end else begin
                state <= ST_FCS;
                eom_q <= 1'b1;
              end
            end else begin
              idx <= idx + IW'(1);
            end
          end
          ST_FCS: begin
            if (idx == FCS_LAST) begin
              state <= ST_CLOSE;
              idx   <= '0;
            end else begin
              idx <= idx + IW'(1);
            end
          end
          ST_CLOSE: begin
            if (idx == FLAG_LAST) state <= ST_END;
            else                  idx   <= idx + IW'(1);
          end
          ST_END: begin
            state <= ST_IDLE;
            rts_q <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign rts_n    = rts_q;
  assign eom_flag = eom_q;

  logic [GW-1:0] gap_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               gap_cnt <= GW'(MIN_BIT_GAP - 1);
    else if (bit_en)                          gap_cnt <= '0;
    else if (gap_cnt < GW'(MIN_BIT_GAP - 1))  gap_cnt <= gap_cnt + GW'(1);
  end

  AST_BIT_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> (gap_cnt >= GW'(MIN_BIT_GAP - 1))); // R11
  AST_QUIET_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(txd) && $stable(rts_n) && $stable(eom_flag))); // R12
  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN_MAX); // R5
  AST_LATCH_CLEAR_AT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rts_n) |-> !eom_flag); // R8
  AST_RELEASE_ON_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_n) |-> txd); // R10
  AST_FLAG_UNSTUFFED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OPEN) |-> (ones == '0)); // R3

endmodule

// File: tb/hdlc_frame_tx_tb.sv
module hdlc_frame_tx_tb;

  typedef struct packed {
    logic        exp_eom;
    logic        nrzi;
    logic [2:0]  len;
    logic [47:0] data;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b1, 1'b0, 3'd1, 48'h000000000000},
    '{1'b1, 1'b0, 3'd3, 48'h000000563412},
    '{1'b1, 1'b0, 3'd2, 48'h00000000FFFF},
    '{1'b1, 1'b1, 3'd2, 48'h000000003F7E},
    '{1'b1, 1'b1, 3'd5, 48'h00551FF88001},
    '{1'b1, 1'b0, 3'd6, 48'hFF00FFFE7FFF}
  };
  localparam logic [7:0] FLAG = 8'h7E;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic       nrzi_mode = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, txd, rts_n, eom_flag;

  logic tick_on = 1'b0;
  int   n_checks = 0;
  int   n_fail = 0;

  logic raw [0:255];
  int   raw_n;
  int   run_len;
  logic exp_line [0:255];
  int   exp_n;
  logic got_line [0:255];
  int   got_n;

  hdlc_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .nrzi_mode(nrzi_mode),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .txd(txd), .rts_n(rts_n), .eom_flag(eom_flag)
  );

  initial forever #4 clk = ~clk;

  // bit tick every 4 clocks (the R11 limit)
  initial begin
    int tcnt = 0;
    forever begin
      @(negedge clk);
      if (tick_on && tcnt == 3) begin
        bit_en = 1'b1;
        tcnt = 0;
      end else begin
        bit_en = 1'b0;
        if (tick_on && tcnt < 3) tcnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic add_bit(input logic b, input bit stuffable);
    raw[raw_n] = b;
    raw_n++;
    if (stuffable) begin
      run_len = b ? run_len + 1 : 0;
      if (run_len == 5) begin
        raw[raw_n] = 1'b0;
        raw_n++;
        run_len = 0;
      end
    end
  endtask

  task automatic build_expected(input logic nrzi, input int len, input logic [47:0] data);
    logic [15:0] crc;
    logic fb, lvl;
    crc = 16'hFFFF;
    raw_n = 0;
    run_len = 0;
    for (int i = 0; i < 8; i++) add_bit(FLAG[i], 1'b0);
    for (int k = 0; k < len; k++) begin
      for (int i = 0; i < 8; i++) begin
        fb  = crc[0] ^ data[8*k+i];
        crc = crc >> 1;
        if (fb) crc = crc ^ 16'h8408;
        add_bit(data[8*k+i], 1'b1);
      end
    end
    for (int i = 0; i < 16; i++) add_bit(~crc[i], 1'b1);
    run_len = 0;
    for (int i = 0; i < 8; i++) add_bit(FLAG[i], 1'b0);
    lvl = 1'b1;
    exp_line[0] = 1'b1;
    for (int j = 0; j < raw_n; j++) begin
      lvl = nrzi ? (raw[j] ? lvl : ~lvl) : raw[j];
      exp_line[j+1] = lvl;
    end
    exp_n = raw_n + 1;
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (bit_en !== 1'b1);
    @(negedge clk);
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect(input logic exp_eom, input string tag);
    int guard;
    int bad;
    guard = 0;
    do begin
      wait_tick();
      guard++;
    end while (rts_n !== 1'b0 && guard < 300);
    check(rts_n == 1'b0, "R3", "rts_n low at frame start", rts_n, 0);
    check(eom_flag == 1'b0, "R8", "latch cleared at frame start", eom_flag, 0);
    got_n = 0;
    got_line[0] = txd;
    got_n = 1;
    guard = 0;
    while (guard < 400) begin
      wait_tick();
      guard++;
      if (rts_n) break;
      if (got_n < 256) begin
        got_line[got_n] = txd;
        got_n++;
      end
    end
    check(txd == 1'b1, "R10", "txd high when rts_n released", txd, 1);
    check(eom_flag == exp_eom, "R7", "underrun latch after frame", eom_flag, exp_eom);
    check(got_n == exp_n, "R4 R7", "frame length in bit ticks", got_n, exp_n);
    bad = -1;
    for (int j = 0; j < got_n && j < exp_n; j++)
      if (bad < 0 && got_line[j] !== exp_line[j]) bad = j;
    check(bad < 0, tag, "line level at first mismatching tick",
          (bad < 0) ? 0 : int'(got_line[bad]), (bad < 0) ? 0 : int'(exp_line[bad]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 / R1: reset state
    check(txd == 1'b1, "R2", "txd after reset", txd, 1);
    check(rts_n == 1'b1, "R2", "rts_n after reset", rts_n, 1);
    check(in_ready == 1'b1, "R1", "in_ready with empty queue", in_ready, 1);
    check(eom_flag == 1'b0, "R7", "latch after reset", eom_flag, 0);
    tick_on = 1'b1;
    repeat (5) wait_tick();
    check(rts_n == 1'b1 && txd == 1'b1, "R2", "idle with no data",
          int'({rts_n, txd}), 3);

    // table of vectors: R3 R4 R5 R6 R9 via the line stream
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      nrzi_mode = VECS[v].nrzi;
      build_expected(VECS[v].nrzi, int'(VECS[v].len), VECS[v].data);
      fork
        begin
          for (int k = 0; k < int'(VECS[v].len); k++)
            push_byte(VECS[v].data[8*k +: 8]);
        end
        collect(VECS[v].exp_eom, VECS[v].nrzi ? "R3 R4 R5 R6 R9" : "R3 R4 R5 R6");
      join
      repeat (3) wait_tick();
      check(rts_n == 1'b1 && txd == 1'b1, "R2", "idle between frames",
            int'({rts_n, txd}), 3);
    end

    // R1: fill the queue with ticks held off, offer one more byte
    tick_on = 1'b0;
    @(negedge clk);
    nrzi_mode = 1'b0;
    push_byte(8'hA5);
    push_byte(8'h0F);
    push_byte(8'hF0);
    check(in_ready == 1'b1, "R1", "ready with three bytes queued", in_ready, 1);
    push_byte(8'h3C);
    check(in_ready == 1'b0, "R1", "not ready with four bytes queued", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'hAA;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R1", "still full after refused offer", in_ready, 0);
    build_expected(1'b0, 4, 48'h00003CF00FA5);
    tick_on = 1'b1;
    collect(1'b1, "R1 R4");
    check(in_ready == 1'b1, "R1", "ready after queue drained", in_ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule